// File: doc/BRIEF.md
# Incremental Encoder Decoder with Timestamp Capture

This block turns the A, B and Z lines of an incremental encoder into a signed position count. It also records when motion events happen. A, B and Z first pass through a synchroniser chain. The decoder then counts A/B transitions at one, two or four counts per cycle, depending on the mode input. An index pulse zeroes the count, but only when it arrives while A/B sit in one programmable state. This lets one mechanical reference define the zero position.

A free-running local timer advances once per clock. A sync strobe reloads it with a supplied system-time value, so stamps from several axes refer to one shared time axis. The block can latch the timer together with the position on three kinds of event: a counted edge, an accepted index, and an external frame-complete strobe from a serial-encoder receiver. A mask picks which kinds are recorded.

Captures leave the block as a record with a one-cycle valid pulse. There is no ready input and no back-pressure. The consumer must take the record in the cycle it is valid, and a later capture overwrites it. When several events fall in the same cycle, only one record is produced, with this priority: index first, then frame, then edge.

Top module: `quad_stamp_unit`

## Requirements
- R1: After reset, `position` is 0, `index_seen` and `quad_err` are 0, and `cap_valid` stays low until an enabled event occurs.
- R2: With `count_mode`=2 (4x), every legal A/B transition changes the count by one. The sequence {A,B} 00→10→11→01→00 increments, and the reverse sequence decrements. A level change on the inputs shows up on `position` three clock edges later.
- R3: With `count_mode`=1 (2x), only A transitions are counted. Counting is forward when the new A differs from B and backward otherwise. B transitions leave the count unchanged.
- R4: With `count_mode`=0 (1x), only rising edges of A are counted. The count goes +1 when B=0 and −1 when B=1. Falling A edges and B edges leave the count unchanged.
- R5: `position` is two's complement and wraps: decrementing from 0 gives all ones.
- R6: A transition in which A and B change together leaves the count unchanged and sets `quad_err`. The flag stays set until reset.
- R7: A rising edge of the synchronised Z input is accepted only when {A,B} equals `idx_state`. An accepted index sets `position` to 0 and sets `index_seen` (sticky). An index in any other state changes neither `position` nor `index_seen`.
- R8: The local timer increments by one every clock. A cycle with `sync_pulse` high loads it with `sync_value` instead.
- R9: An event whose `cap_mask` bit is set (bit0 edge, bit1 index, bit2 frame) raises `cap_valid` for exactly one cycle on the following edge. The record carries the timer value of the event cycle, the position after the event, and `cap_kind` (1 edge, 2 index, 3 frame). Masked events produce no record.
- R10: When a sync load and a capture fall in the same cycle, `cap_time` holds the timer value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder track A (asynchronous) |
| enc_b | input | 1 | Encoder track B (asynchronous) |
| enc_z | input | 1 | Encoder index track (asynchronous) |
| count_mode | input | 2 | 0 = 1x, 1 = 2x, 2 or 3 = 4x |
| idx_state | input | 2 | {A,B} state in which an index is accepted |
| cap_mask | input | 3 | Capture enables: bit0 edge, bit1 index, bit2 frame |
| frame_done | input | 1 | Frame-complete strobe, same clock domain |
| sync_pulse | input | 1 | Timer reload strobe |
| sync_value | input | TS_W | Value loaded into the timer on sync |
| position | output | POS_W | Signed position count |
| cap_valid | output | 1 | One-cycle capture valid pulse |
| cap_time | output | TS_W | Captured timer value |
| cap_pos | output | POS_W | Captured position |
| cap_kind | output | 2 | Event type of the capture |
| index_seen | output | 1 | Sticky accepted-index flag |
| quad_err | output | 1 | Sticky illegal-transition flag |

## Verification
The bench walks the Gray sequence in every mode and in both directions. A decoder with a swapped direction rule, or one that counts B edges in 2x or falling A edges in 1x, drifts off the expected count within a few vectors. It also steps the count below zero: a design that saturates instead of wrapping would hold 0 there. An index pulse is sent in the wrong A/B state, where a design that ignores the gate would zero the count. Timer stamps are checked against known sync loads, including a load in the same cycle as a frame strobe. A design that samples the timer after the load, or that is off by one in its capture stage, would report the wrong stamp there.

// File: rtl/qs_pkg.sv
package qs_pkg;
  typedef enum logic [1:0] {
    CNT_1X = 2'd0,
    CNT_2X = 2'd1,
    CNT_4X = 2'd2
  } cnt_mode_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_EDGE  = 2'd1,
    EV_INDEX = 2'd2,
    EV_FRAME = 2'd3
  } ev_kind_e;

  localparam int unsigned MASK_EDGE  = 0;
  localparam int unsigned MASK_INDEX = 1;
  localparam int unsigned MASK_FRAME = 2;
endpackage

// File: rtl/qs_sync.sv
module qs_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/qs_quad.sv
module qs_quad
  import qs_pkg::*;
#(
  parameter int unsigned POS_W  = 16,
  parameter int unsigned SETTLE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_s,
  input  logic             b_s,
  input  logic             z_s,
  input  logic [1:0]       mode,
  input  logic [1:0]       idx_state,
  output logic [POS_W-1:0] position,
  output logic [POS_W-1:0] pos_next,
  output logic             step_ev,
  output logic             index_ev,
  output logic             index_seen,
  output logic             quad_err
);
  localparam int unsigned SW = $clog2(SETTLE + 1);

  logic [SW-1:0] settle_q;
  logic          armed;
  logic          a_p, b_p, z_p;
  logic          a_chg, b_chg, illegal, cnt_en, fwd;
  cnt_mode_e     mode_e;

  assign armed  = (settle_q == SW'(SETTLE));
  assign mode_e = cnt_mode_e'(mode);
  assign a_chg  = a_s ^ a_p;
  assign b_chg  = b_s ^ b_p;
  assign illegal = armed & a_chg & b_chg;

  always_comb begin
    unique case (mode_e)
      CNT_1X: begin
        cnt_en = armed & a_chg & a_s & ~b_chg;
        fwd    = (a_s != b_s);
      end
      CNT_2X: begin
        cnt_en = armed & a_chg & ~b_chg;
        fwd    = (a_s != b_s);
      end
      default: begin
        cnt_en = armed & (a_chg ^ b_chg);
        fwd    = a_chg ? (a_s != b_s) : (b_s == a_s);
      end
    endcase
  end

  assign index_ev = armed & z_s & ~z_p & ({a_s, b_s} == idx_state);
  assign step_ev  = cnt_en;

  always_comb begin
    if (index_ev)    pos_next = '0;
    else if (cnt_en) pos_next = fwd ? position + 1'b1 : position - 1'b1;
    else             pos_next = position;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q   <= '0;
      a_p        <= 1'b0;
      b_p        <= 1'b0;
      z_p        <= 1'b0;
      position   <= '0;
      index_seen <= 1'b0;
      quad_err   <= 1'b0;
    end else begin
      if (!armed) settle_q <= settle_q + 1'b1;
      a_p      <= a_s;
      b_p      <= b_s;
      z_p      <= z_s;
      position <= pos_next;
      if (index_ev) index_seen <= 1'b1;
      if (illegal)  quad_err   <= 1'b1;
    end
  end
endmodule

// File: rtl/qs_timebase.sv
module qs_timebase #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_pulse,
  input  logic [TS_W-1:0] sync_value,
  output logic [TS_W-1:0] tmr_now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tmr_now <= '0;
    else if (sync_pulse) tmr_now <= sync_value;
    else                 tmr_now <= tmr_now + 1'b1;
  end
endmodule

// File: rtl/qs_capture.sv
module qs_capture
  import qs_pkg::*;
#(
  parameter int unsigned POS_W = 16,
  parameter int unsigned TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cap_mask,
  input  logic             step_ev,
  input  logic             index_ev,
  input  logic             frame_ev,
  input  logic [TS_W-1:0]  tmr_now,
  input  logic [POS_W-1:0] pos_next,
  output logic             cap_valid,
  output logic [TS_W-1:0]  cap_time,
  output logic [POS_W-1:0] cap_pos,
  output logic [1:0]       cap_kind
);
  ev_kind_e kind_sel;

  always_comb begin
    if (index_ev && cap_mask[MASK_INDEX])      kind_sel = EV_INDEX;
    else if (frame_ev && cap_mask[MASK_FRAME]) kind_sel = EV_FRAME;
    else if (step_ev && cap_mask[MASK_EDGE])   kind_sel = EV_EDGE;
    else                                       kind_sel = EV_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_time  <= '0;
      cap_pos   <= '0;
      cap_kind  <= EV_NONE;
    end else begin
      cap_valid <= (kind_sel != EV_NONE);
      if (kind_sel != EV_NONE) begin
        cap_time <= tmr_now;
        cap_pos  <= pos_next;
        cap_kind <= kind_sel;
      end
    end
  end
endmodule

// File: rtl/quad_stamp_unit.sv
module quad_stamp_unit #(
  parameter int unsigned POS_W       = 16,
  parameter int unsigned TS_W        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_z,
  input  logic [1:0]       count_mode,
  input  logic [1:0]       idx_state,
  input  logic [2:0]       cap_mask,
  input  logic             frame_done,
  input  logic             sync_pulse,
  input  logic [TS_W-1:0]  sync_value,
  output logic [POS_W-1:0] position,
  output logic             cap_valid,
  output logic [TS_W-1:0]  cap_time,
  output logic [POS_W-1:0] cap_pos,
  output logic [1:0]       cap_kind,
  output logic             index_seen,
  output logic             quad_err
);
  localparam int unsigned SETTLE = SYNC_STAGES + 1;

  logic [2:0]       abz_s;
  logic [POS_W-1:0] pos_next;
  logic             step_ev, index_ev;
  logic [TS_W-1:0]  tmr_now;

  qs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({enc_z, enc_b, enc_a}), .d_out(abz_s)
  );

  qs_quad #(.POS_W(POS_W), .SETTLE(SETTLE)) u_quad (
    .clk(clk), .rst_n(rst_n),
    .a_s(abz_s[0]), .b_s(abz_s[1]), .z_s(abz_s[2]),
    .mode(count_mode), .idx_state(idx_state),
    .position(position), .pos_next(pos_next),
    .step_ev(step_ev), .index_ev(index_ev),
    .index_seen(index_seen), .quad_err(quad_err)
  );

  qs_timebase #(.TS_W(TS_W)) u_time (
    .clk(clk), .rst_n(rst_n),
    .sync_pulse(sync_pulse), .sync_value(sync_value), .tmr_now(tmr_now)
  );

  qs_capture #(.POS_W(POS_W), .TS_W(TS_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_mask(cap_mask),
    .step_ev(step_ev), .index_ev(index_ev), .frame_ev(frame_done),
    .tmr_now(tmr_now), .pos_next(pos_next),
    .cap_valid(cap_valid), .cap_time(cap_time),
    .cap_pos(cap_pos), .cap_kind(cap_kind)
  );
endmodule

// File: rtl/quad_stamp_chk.sv
module quad_stamp_chk #(
  parameter int unsigned POS_W = 16,
  parameter int unsigned TS_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] position,
  input logic             quad_err,
  input logic             index_seen,
  input logic             cap_valid,
  input logic [1:0]       cap_kind,
  input logic [2:0]       cap_mask,
  input logic             sync_pulse,
  input logic [TS_W-1:0]  sync_value,
  input logic [TS_W-1:0]  tmr_now
);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quad_err |=> quad_err);

  // R7
  index_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    index_seen |=> index_seen);

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (position != $past(position)) |->
      (position == POS_W'($past(position) + 1'b1)) ||
      (position == POS_W'($past(position) - 1'b1)) ||
      (position == '0));

  // R8
  timer_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_pulse |=> (tmr_now == TS_W'($past(tmr_now) + 1'b1)));

  // R8
  timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> (tmr_now == $past(sync_value)));

  // R9
  kind_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> (cap_kind != 2'd0));

  // R9
  frame_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_kind == 2'd3) |-> $past(cap_mask[2]));
endmodule

bind quad_stamp_unit quad_stamp_chk #(.POS_W(POS_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .position(position), .quad_err(quad_err),
  .index_seen(index_seen), .cap_valid(cap_valid), .cap_kind(cap_kind),
  .cap_mask(cap_mask), .sync_pulse(sync_pulse), .sync_value(sync_value),
  .tmr_now(tmr_now)
);

// File: tb/quad_stamp_unit_test.sv
`timescale 1ns/1ps
module quad_stamp_unit_test;
  localparam int POS_W = 16;
  localparam int TS_W  = 32;
  localparam int NVEC  = 22;

  // {mode[1:0], A, B, expected position[15:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {2'd2, 1'b1, 1'b0, 16'd1},    {2'd2, 1'b1, 1'b1, 16'd2},
    {2'd2, 1'b0, 1'b1, 16'd3},    {2'd2, 1'b0, 1'b0, 16'd4},
    {2'd2, 1'b0, 1'b1, 16'd3},    {2'd2, 1'b0, 1'b0, 16'd4},
    {2'd1, 1'b1, 1'b0, 16'd5},    {2'd1, 1'b1, 1'b1, 16'd5},
    {2'd1, 1'b0, 1'b1, 16'd6},    {2'd1, 1'b1, 1'b1, 16'd5},
    {2'd0, 1'b0, 1'b1, 16'd5},    {2'd0, 1'b0, 1'b0, 16'd5},
    {2'd0, 1'b1, 1'b0, 16'd6},    {2'd0, 1'b0, 1'b0, 16'd6},
    {2'd0, 1'b0, 1'b1, 16'd6},    {2'd0, 1'b1, 1'b1, 16'd5},
    {2'd2, 1'b1, 1'b0, 16'd4},    {2'd2, 1'b0, 1'b0, 16'd3},
    {2'd2, 1'b0, 1'b1, 16'd2},    {2'd2, 1'b1, 1'b1, 16'd1},
    {2'd2, 1'b1, 1'b0, 16'd0},    {2'd2, 1'b0, 1'b0, 16'hFFFF}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
  logic [1:0]       count_mode = 2'd2;
  logic [1:0]       idx_state = 2'd0;
  logic [2:0]       cap_mask = 3'd0;
  logic             frame_done = 1'b0;
  logic             sync_pulse = 1'b0;
  logic [TS_W-1:0]  sync_value = '0;
  logic [POS_W-1:0] position;
  logic             cap_valid;
  logic [TS_W-1:0]  cap_time;
  logic [POS_W-1:0] cap_pos;
  logic [1:0]       cap_kind;
  logic             index_seen, quad_err;

  int checks = 0, failures = 0, cap_cnt = 0;
  logic [TS_W-1:0]  last_time;
  logic [POS_W-1:0] last_pos;
  logic [1:0]       last_kind;

  always #2.5 clk = ~clk;

  quad_stamp_unit #(.POS_W(POS_W), .TS_W(TS_W)) uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .count_mode(count_mode), .idx_state(idx_state), .cap_mask(cap_mask),
    .frame_done(frame_done), .sync_pulse(sync_pulse), .sync_value(sync_value),
    .position(position), .cap_valid(cap_valid), .cap_time(cap_time),
    .cap_pos(cap_pos), .cap_kind(cap_kind), .index_seen(index_seen),
    .quad_err(quad_err)
  );

  always @(negedge clk) begin
    if (rst_n && cap_valid) begin
      cap_cnt++;
      last_time = cap_time;
      last_pos  = cap_pos;
      last_kind = cap_kind;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_z();
    @(negedge clk); enc_z = 1'b1;
    repeat (4) @(negedge clk); enc_z = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int c0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk("R1 position", position, 0);
    chk("R1 index_seen", index_seen, 0);
    chk("R1 quad_err", quad_err, 0);
    chk("R1 no capture", cap_cnt, 0);

    // R2 R3 R4 R5 vector walk, captures masked
    for (int i = 0; i < NVEC; i++) begin
      count_mode = VEC[i][19:18];
      step(VEC[i][17], VEC[i][16]);
      chk($sformatf("R2/R3/R4/R5 vec%0d", i), position, VEC[i][15:0]);
    end
    chk("R2 no error on legal walk", quad_err, 0);
    chk("R9 masked edges give no record", cap_cnt, 0);

    // R7 index gating
    count_mode = 2'd2;
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk("R7 setup", position, 1);
    idx_state = 2'b10;
    pulse_z();
    chk("R7 wrong state ignored pos", position, 1);
    chk("R7 wrong state ignored flag", index_seen, 0);
    idx_state = 2'b11;
    cap_mask = 3'b010;
    c0 = cap_cnt;
    pulse_z();
    chk("R7 index zeroes", position, 0);
    chk("R7 index_seen", index_seen, 1);
    chk("R9 index record count", cap_cnt - c0, 1);
    chk("R9 index kind", last_kind, 2);
    chk("R9 index pos", last_pos, 0);

    // R8 R9 frame capture against loaded timer
    cap_mask = 3'b100;
    @(negedge clk); sync_pulse = 1'b1; sync_value = 32'd1000;
    @(negedge clk); sync_pulse = 1'b0;
    repeat (4) @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    @(negedge clk);
    chk("R8 frame stamp", last_time, 32'd1004);
    chk("R9 frame kind", last_kind, 3);

    // R10 sync and capture in one cycle
    @(negedge clk); sync_pulse = 1'b1; sync_value = 32'd5000;
    @(negedge clk); sync_value = 32'd9000; frame_done = 1'b1;
    @(negedge clk); sync_pulse = 1'b0; frame_done = 1'b0;
    @(negedge clk);
    chk("R10 pre-load stamp", last_time, 32'd5000);
    frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    @(negedge clk);
    chk("R8 post-load stamp", last_time, 32'd9001);

    // R9 edge capture
    cap_mask = 3'b001;
    c0 = cap_cnt;
    @(negedge clk); sync_pulse = 1'b1; sync_value = 32'd200;
    @(negedge clk); sync_pulse = 1'b0; enc_a = 1'b1; enc_b = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 edge record count", cap_cnt - c0, 1);
    chk("R9 edge stamp", last_time, 32'd202);
    chk("R9 edge pos", last_pos, 16'hFFFF);
    chk("R9 edge kind", last_kind, 1);

    // R9 all masked
    cap_mask = 3'b000;
    c0 = cap_cnt;
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    step(1'b0, 1'b0);
    chk("R9 fully masked", cap_cnt - c0, 0);
    chk("R9 masked step still counts", position, 16'hFFFE);

    // R6 illegal jump, state 00 -> 11
    step(1'b1, 1'b1);
    chk("R6 count held", position, 16'hFFFE);
    chk("R6 error set", quad_err, 1);
    step(1'b1, 1'b0);
    chk("R6 error sticky", quad_err, 1);
    chk("R6 counting resumes", position, 16'hFFFD);

    // R1 second reset clears flags
    enc_a = 1'b0; enc_b = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 re-reset position", position, 0);
    chk("R1 re-reset quad_err", quad_err, 0);
    chk("R1 re-reset index_seen", index_seen, 0);

    finish_run();
  end
endmodule